// File: doc/BRIEF.md
# Strap-Pin Configuration Register Controller

This block holds the management register file of a four-port network transceiver and derives each port's control bits from board-level strap pins. The strap inputs are a global auto-negotiation enable, a global speed select, a global full-duplex select, a global fiber-duplex select, and one media-select pin per port. A mode pin picks how the straps and the management port share the registers.

With the mode pin low, the straps only seed the registers once after reset. From then on, the management write port alone changes register contents. With the mode pin high, management writes are ignored, and the strap-controlled bits are refreshed from the pins every cycle. A high media-select pin puts its port into fiber operation and overrides the global twisted-pair straps for that port. All pins pass through a two-flop synchronizer before they are used.

The management side is a bit-masked write port and a registered read port, both addressed by port number and register number. Registers 0 and 19 exist once per port. The other implemented numbers are shared by all ports.

Top module: `strap_cfg_regs`

## Requirements
- R1: While the synchronized mode pin is high and seeding has finished, management writes have no effect on any register.
- R2: While the mode pin is low after seeding, no register changes unless a management write addresses it; strap pin changes have no effect.
- R3: During reset every register reads zero. Once seeding completes (at most 6 cycles after reset release), bits 0.13, 0.12 and 0.8 and bit 19.2 of each port hold the strap-derived values, and all other bits are zero.
- R4: A port whose media-select pin is high gets 0.13=1, 0.12=0, 19.2=1, and 0.8 equal to the fiber-duplex pin.
- R5: For a port in fiber mode, the global speed, full-duplex and auto-negotiation pins do not affect its bits.
- R6: A twisted-pair port (media-select low) gets 0.13 equal to the speed pin (1 = 100 Mb/s), 0.8 equal to the full-duplex pin, 0.12 equal to the auto-negotiation pin, and 19.2=0.
- R7: In manual mode, a pin change reaches the strap-controlled bits within 4 cycles, and all other bits keep their values.
- R8: Register numbers 0 to 6 and 16 to 20 are implemented. Registers 0 and 19 are per port and the others are shared by all ports. A read of any other number returns zero, and a write to one is ignored.
- R9: A read request returns the register contents with a valid strobe exactly one cycle later. The valid strobe is low in every cycle that follows no read request.
- R10: A write changes only the bits whose write-mask bit is 1, setting each of them to the corresponding write-data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| manualModePin | input | 1 | High selects continuous strap tracking with writes locked out |
| autoNegPin | input | 1 | Global auto-negotiation enable strap |
| speedPin | input | 1 | Global speed strap, 1 = 100 Mb/s |
| fullDuplexPin | input | 1 | Global twisted-pair full-duplex strap |
| fiberDuplexPin | input | 1 | Global fiber full-duplex strap |
| mediaFiberPin | input | NUM_PORTS | Per-port fiber select strap |
| mgmtWrEn | input | 1 | Management write request |
| mgmtRdEn | input | 1 | Management read request |
| mgmtPort | input | PORT_W | Addressed port |
| mgmtReg | input | 5 | Addressed register number |
| mgmtWrData | input | 16 | Write data |
| mgmtWrMask | input | 16 | Per-bit write enable |
| rdData | output | 16 | Read data, one cycle after request |
| rdValid | output | 1 | Read data valid strobe |
| ctrlRegOut | output | NUM_PORTS*16 | Register 0 of every port, port 0 in the low slice |
| mediaRegOut | output | NUM_PORTS*16 | Register 19 of every port, port 0 in the low slice |

## Verification
The assertions assume that reset is applied before any check and that the pins are quasi-static relative to the clock, so the synchronizer output is a clean level. They also assume that reads and writes are single-cycle requests whose address is held for that cycle. The stimulus drives every input at the falling edge. It changes strap pins only between operations and then waits several cycles before checking, and it switches the mode pin only while no write is pending. Random writes and reads cover all 32 register numbers with random masks, so unimplemented numbers and partial-bit writes are exercised in both modes.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int REG_W      = 16;
  localparam int REG_ADDR_W = 5;
  localparam int NUM_SHARED = 10;
  localparam int SHARED_W   = $clog2(NUM_SHARED);

  localparam logic [REG_ADDR_W-1:0] REG_CTRL  = 5'd0;
  localparam logic [REG_ADDR_W-1:0] REG_MEDIA = 5'd19;

  localparam int BIT_SPEED  = 13;
  localparam int BIT_ANEG   = 12;
  localparam int BIT_DUPLEX = 8;
  localparam int BIT_FIBER  = 2;

  typedef struct packed {
    logic loadStraps;
    logic wrEnable;
    logic rdEnable;
  } ctrl_strobe_t;

  function automatic logic isImplemented(input logic [REG_ADDR_W-1:0] r);
    return (r <= 5'd6) || ((r >= 5'd16) && (r <= 5'd20));
  endfunction

  function automatic logic isShared(input logic [REG_ADDR_W-1:0] r);
    return isImplemented(r) && (r != REG_CTRL) && (r != REG_MEDIA);
  endfunction

  function automatic logic [SHARED_W-1:0] sharedIdx(input logic [REG_ADDR_W-1:0] r);
    logic [SHARED_W-1:0] idx;
    if (r <= 5'd6)       idx = SHARED_W'(r - 5'd1);
    else if (r <= 5'd18) idx = SHARED_W'(r - 5'd10);
    else                 idx = SHARED_W'(9);
    return idx;
  endfunction
endpackage

// File: rtl/strap_cfg_sync.sv
module strap_cfg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[0] <= '0;
          else       stageQ[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/strap_cfg_ctrl.sv
module strap_cfg_ctrl
  import strap_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         manualSync,
  input  logic         mgmtWrEn,
  input  logic         mgmtRdEn,
  output ctrl_strobe_t strobe
);
  localparam int CNT_W = $clog2(SYNC_STAGES + 1);

  typedef enum logic [1:0] {ST_WAIT, ST_SEED, ST_RUN} ctrl_state_e;

  ctrl_state_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    unique case (stateQ)
      ST_WAIT: begin
        if (cntQ == CNT_W'(SYNC_STAGES - 1)) stateD = ST_SEED;
        else                                 cntD   = cntQ + 1'b1;
      end
      ST_SEED: stateD = ST_RUN;
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_WAIT;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  always_comb begin
    strobe.loadStraps = (stateQ == ST_SEED) || ((stateQ == ST_RUN) && manualSync);
    strobe.wrEnable   = (stateQ == ST_RUN) && !manualSync && mgmtWrEn;
    strobe.rdEnable   = mgmtRdEn;
  end

  // R3: seeding happens in a single cycle and is followed by normal operation
  assert_seed_once_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SEED) |=> (stateQ == ST_RUN));

  // R1: once running, the mode pin alone selects refresh versus write access
  assert_run_exclusive_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN) |-> !(strobe.loadStraps && strobe.wrEnable));
endmodule

// File: rtl/strap_cfg_datapath.sv
module strap_cfg_datapath
  import strap_cfg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_strobe_t               strobe,
  input  logic                       autoNegSync,
  input  logic                       speedSync,
  input  logic                       fullDuplexSync,
  input  logic                       fiberDuplexSync,
  input  logic [NUM_PORTS-1:0]       fiberSync,
  input  logic [PORT_W-1:0]          mgmtPort,
  input  logic [REG_ADDR_W-1:0]      mgmtReg,
  input  logic [REG_W-1:0]           mgmtWrData,
  input  logic [REG_W-1:0]           mgmtWrMask,
  output logic [REG_W-1:0]           rdData,
  output logic                       rdValid,
  output logic [NUM_PORTS*REG_W-1:0] ctrlFlat,
  output logic [NUM_PORTS*REG_W-1:0] mediaFlat
);
  logic [REG_W-1:0] ctrlReg   [NUM_PORTS];
  logic [REG_W-1:0] mediaReg  [NUM_PORTS];
  logic [REG_W-1:0] sharedReg [NUM_SHARED];
  logic [NUM_SHARED*REG_W-1:0] sharedFlat;

  function automatic logic [REG_W-1:0] maskedMerge(input logic [REG_W-1:0] oldVal,
                                                   input logic [REG_W-1:0] data,
                                                   input logic [REG_W-1:0] mask);
    return (oldVal & ~mask) | (data & mask);
  endfunction

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic portHit;
      logic isFiber;
      logic [REG_W-1:0] ctrlD, mediaD;

      assign portHit = strobe.wrEnable && (mgmtPort == PORT_W'(p));
      assign isFiber = fiberSync[p];

      always_comb begin
        ctrlD  = ctrlReg[p];
        mediaD = mediaReg[p];
        if (portHit && (mgmtReg == REG_CTRL))
          ctrlD = maskedMerge(ctrlD, mgmtWrData, mgmtWrMask);
        if (portHit && (mgmtReg == REG_MEDIA))
          mediaD = maskedMerge(mediaD, mgmtWrData, mgmtWrMask);
        if (strobe.loadStraps) begin
          ctrlD[BIT_SPEED]  = isFiber | speedSync;
          ctrlD[BIT_ANEG]   = !isFiber & autoNegSync;
          ctrlD[BIT_DUPLEX] = isFiber ? fiberDuplexSync : fullDuplexSync;
          mediaD[BIT_FIBER] = isFiber;
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ctrlReg[p]  <= '0;
          mediaReg[p] <= '0;
        end else begin
          ctrlReg[p]  <= ctrlD;
          mediaReg[p] <= mediaD;
        end
      end

      assign ctrlFlat[p*REG_W +: REG_W]  = ctrlReg[p];
      assign mediaFlat[p*REG_W +: REG_W] = mediaReg[p];

      // R4: a refresh on a fiber port forces speed, clears auto-negotiation, sets fiber select
      assert_fiber_force_R4: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.loadStraps && fiberSync[p]) |=>
          (ctrlFlat[p*REG_W + BIT_SPEED] && !ctrlFlat[p*REG_W + BIT_ANEG] &&
           mediaFlat[p*REG_W + BIT_FIBER] &&
           (ctrlFlat[p*REG_W + BIT_DUPLEX] == $past(fiberDuplexSync))));

      // R6: a refresh on a twisted-pair port copies the global pins and clears fiber select
      assert_tp_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.loadStraps && !fiberSync[p]) |=>
          (!mediaFlat[p*REG_W + BIT_FIBER] &&
           (ctrlFlat[p*REG_W + BIT_SPEED] == $past(speedSync)) &&
           (ctrlFlat[p*REG_W + BIT_DUPLEX] == $past(fullDuplexSync))));

      // R10: unmasked bits of the addressed control register are kept
      assert_mask_keep_R10: assert property (@(posedge clk) disable iff (!rstN)
        (portHit && (mgmtReg == REG_CTRL) && !strobe.loadStraps) |=>
          ((ctrlFlat[p*REG_W +: REG_W] & ~$past(mgmtWrMask)) ==
           ($past(ctrlFlat[p*REG_W +: REG_W]) & ~$past(mgmtWrMask))));
    end

    for (genvar i = 0; i < NUM_SHARED; i++) begin : g_shared
      logic hit;
      assign hit = strobe.wrEnable && isShared(mgmtReg) &&
                   (sharedIdx(mgmtReg) == SHARED_W'(i));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)    sharedReg[i] <= '0;
        else if (hit) sharedReg[i] <= maskedMerge(sharedReg[i], mgmtWrData, mgmtWrMask);
      end
      assign sharedFlat[i*REG_W +: REG_W] = sharedReg[i];
    end
  endgenerate

  logic [REG_W-1:0] rdMux;
  always_comb begin
    rdMux = '0;
    if (mgmtReg == REG_CTRL)       rdMux = ctrlReg[mgmtPort];
    else if (mgmtReg == REG_MEDIA) rdMux = mediaReg[mgmtPort];
    else if (isShared(mgmtReg))    rdMux = sharedReg[sharedIdx(mgmtReg)];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.rdEnable;
      if (strobe.rdEnable) rdData <= rdMux;
    end
  end

  // R1: while the pins own the registers, the shared registers never move
  assert_locked_shared_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadStraps |=> $stable(sharedFlat));

  // R2: without a refresh or a write nothing in the register file changes
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadStraps && !strobe.wrEnable) |=>
      ($stable(ctrlFlat) && $stable(mediaFlat) && $stable(sharedFlat)));

  // R8: unimplemented register numbers read back as zero
  assert_unimpl_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEnable && !isImplemented(mgmtReg)) |=> (rdData == '0));

  // R9: valid strobe follows the request by exactly one cycle
  assert_read_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEnable |=> rdValid);
  assert_read_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEnable |=> !rdValid);
endmodule

// File: rtl/strap_cfg_regs.sv
module strap_cfg_regs
  import strap_cfg_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PORT_W      = $clog2(NUM_PORTS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       manualModePin,
  input  logic                       autoNegPin,
  input  logic                       speedPin,
  input  logic                       fullDuplexPin,
  input  logic                       fiberDuplexPin,
  input  logic [NUM_PORTS-1:0]       mediaFiberPin,
  input  logic                       mgmtWrEn,
  input  logic                       mgmtRdEn,
  input  logic [PORT_W-1:0]          mgmtPort,
  input  logic [REG_ADDR_W-1:0]      mgmtReg,
  input  logic [REG_W-1:0]           mgmtWrData,
  input  logic [REG_W-1:0]           mgmtWrMask,
  output logic [REG_W-1:0]           rdData,
  output logic                       rdValid,
  output logic [NUM_PORTS*REG_W-1:0] ctrlRegOut,
  output logic [NUM_PORTS*REG_W-1:0] mediaRegOut
);
  localparam int PIN_W = NUM_PORTS + 5;

  logic [PIN_W-1:0] pinRaw, pinSync;
  ctrl_strobe_t strobe;

  assign pinRaw = {mediaFiberPin, fiberDuplexPin, fullDuplexPin, speedPin,
                   autoNegPin, manualModePin};

  strap_cfg_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinRaw),
    .dout (pinSync)
  );

  strap_cfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .manualSync (pinSync[0]),
    .mgmtWrEn   (mgmtWrEn),
    .mgmtRdEn   (mgmtRdEn),
    .strobe     (strobe)
  );

  strap_cfg_datapath #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .autoNegSync     (pinSync[1]),
    .speedSync       (pinSync[2]),
    .fullDuplexSync  (pinSync[3]),
    .fiberDuplexSync (pinSync[4]),
    .fiberSync       (pinSync[PIN_W-1:5]),
    .mgmtPort        (mgmtPort),
    .mgmtReg         (mgmtReg),
    .mgmtWrData      (mgmtWrData),
    .mgmtWrMask      (mgmtWrMask),
    .rdData          (rdData),
    .rdValid         (rdValid),
    .ctrlFlat        (ctrlRegOut),
    .mediaFlat       (mediaRegOut)
  );
endmodule

// File: tb/strap_cfg_regs_tb.sv
module strap_cfg_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic manualModePin = 1'b0, autoNegPin = 1'b0, speedPin = 1'b0;
  logic fullDuplexPin = 1'b0, fiberDuplexPin = 1'b0;
  logic [NP-1:0] mediaFiberPin = '0;
  logic mgmtWrEn = 1'b0, mgmtRdEn = 1'b0;
  logic [1:0] mgmtPort = '0;
  logic [4:0] mgmtReg = '0;
  logic [15:0] mgmtWrData = '0, mgmtWrMask = '0;
  logic [15:0] rdData;
  logic rdValid;
  logic [NP*16-1:0] ctrlRegOut, mediaRegOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] mReg0 [NP];
  logic [15:0] mReg19 [NP];
  logic [15:0] mShared [32];
  bit manualModel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_cfg_regs u_dut (
    .clk(clk), .rstN(rstN), .manualModePin(manualModePin), .autoNegPin(autoNegPin),
    .speedPin(speedPin), .fullDuplexPin(fullDuplexPin), .fiberDuplexPin(fiberDuplexPin),
    .mediaFiberPin(mediaFiberPin), .mgmtWrEn(mgmtWrEn), .mgmtRdEn(mgmtRdEn),
    .mgmtPort(mgmtPort), .mgmtReg(mgmtReg), .mgmtWrData(mgmtWrData),
    .mgmtWrMask(mgmtWrMask), .rdData(rdData), .rdValid(rdValid),
    .ctrlRegOut(ctrlRegOut), .mediaRegOut(mediaRegOut)
  );

  function automatic bit implReg(input logic [4:0] r);
    return (r <= 6) || (r >= 16 && r <= 20);
  endfunction

  function automatic logic [15:0] expRead(input logic [1:0] p, input logic [4:0] r);
    if (!implReg(r)) return 16'h0;
    if (r == 0)  return mReg0[p];
    if (r == 19) return mReg19[p];
    return mShared[r];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // strap-derived bits: 0.13 speed, 0.12 auto-neg, 0.8 duplex, 19.2 fiber
  task automatic modelStraps();
    for (int p = 0; p < NP; p++) begin
      if (mediaFiberPin[p]) begin
        mReg0[p][13] = 1'b1;
        mReg0[p][12] = 1'b0;
        mReg0[p][8]  = fiberDuplexPin;
        mReg19[p][2] = 1'b1;
      end else begin
        mReg0[p][13] = speedPin;
        mReg0[p][12] = autoNegPin;
        mReg0[p][8]  = fullDuplexPin;
        mReg19[p][2] = 1'b0;
      end
    end
  endtask

  task automatic checkOutputs(input string req);
    for (int p = 0; p < NP; p++) begin
      check(req, {16'h0, ctrlRegOut[p*16 +: 16]}, {16'h0, mReg0[p]});
      check(req, {16'h0, mediaRegOut[p*16 +: 16]}, {16'h0, mReg19[p]});
    end
  endtask

  task automatic doWrite(input logic [1:0] p, input logic [4:0] r,
                         input logic [15:0] d, input logic [15:0] m);
    @(negedge clk);
    mgmtWrEn = 1'b1; mgmtPort = p; mgmtReg = r; mgmtWrData = d; mgmtWrMask = m;
    @(negedge clk);
    mgmtWrEn = 1'b0;
    if (!manualModel && implReg(r)) begin
      if (r == 0)       mReg0[p]   = (mReg0[p] & ~m) | (d & m);
      else if (r == 19) mReg19[p]  = (mReg19[p] & ~m) | (d & m);
      else              mShared[r] = (mShared[r] & ~m) | (d & m);
    end
    check("R9 idle valid", {31'h0, rdValid}, 32'h0);
  endtask

  task automatic doRead(input string req, input logic [1:0] p, input logic [4:0] r);
    @(negedge clk);
    mgmtRdEn = 1'b1; mgmtPort = p; mgmtReg = r;
    @(negedge clk);
    mgmtRdEn = 1'b0;
    check("R9 valid", {31'h0, rdValid}, 32'h1);
    check(req, {16'h0, rdData}, {16'h0, expRead(p, r)});
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5813));
    for (int p = 0; p < NP; p++) begin mReg0[p] = '0; mReg19[p] = '0; end
    for (int r = 0; r < 32; r++) mShared[r] = '0;

    // R3 reset state with straps set: fiber on ports 0 and 2
    autoNegPin = 1'b1; speedPin = 1'b0; fullDuplexPin = 1'b1;
    fiberDuplexPin = 1'b0; mediaFiberPin = 4'b0101;
    waitCycles(3);
    checkOutputs("R3 reset zero");
    rstN = 1'b1;
    waitCycles(6);
    modelStraps();
    checkOutputs("R3 R4 R5 R6 seed");

    // R2: pin changes in write mode do nothing
    speedPin = 1'b1; fullDuplexPin = 1'b0; autoNegPin = 1'b0;
    fiberDuplexPin = 1'b1; mediaFiberPin = 4'b1010;
    waitCycles(6);
    checkOutputs("R2 pins ignored");

    // R10 masked write and R8 addressing
    doWrite(2'd2, 5'd0, 16'hFFFF, 16'h00F0);
    doRead("R10 masked", 2'd2, 5'd0);
    doRead("R8 per-port copy", 2'd1, 5'd0);
    doWrite(2'd0, 5'd7, 16'hABCD, 16'hFFFF);
    doRead("R8 unimplemented", 2'd0, 5'd7);
    doWrite(2'd3, 5'd17, 16'h1234, 16'hFFFF);
    doRead("R8 shared", 2'd0, 5'd17);
    doWrite(2'd1, 5'd19, 16'h5A5A, 16'h0FF0);
    doRead("R8 media per port", 2'd1, 5'd19);

    // random traffic in write mode
    for (int i = 0; i < 300; i++) begin
      logic [1:0] p;
      logic [4:0] r;
      p = 2'($urandom_range(0, 3));
      r = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 1) == 0)
        doWrite(p, r, 16'($urandom), 16'($urandom));
      else
        doRead("R8 R10 random", p, r);
    end
    checkOutputs("R2 R10 random outputs");

    // switch to manual mode
    manualModePin = 1'b1;
    waitCycles(6);
    manualModel = 1;
    modelStraps();
    checkOutputs("R7 manual entry");
    doWrite(2'd0, 5'd0, 16'h0000, 16'hFFFF);
    doRead("R1 locked ctrl", 2'd0, 5'd0);
    doWrite(2'd0, 5'd3, 16'hFFFF, 16'hFFFF);
    doRead("R1 locked shared", 2'd0, 5'd3);

    // directed: all fiber, global pins toggled (R5)
    mediaFiberPin = 4'b1111; fiberDuplexPin = 1'b1;
    speedPin = 1'b0; autoNegPin = 1'b1; fullDuplexPin = 1'b0;
    waitCycles(4);
    modelStraps();
    checkOutputs("R4 R5 all fiber");
    speedPin = 1'b1; autoNegPin = 1'b0; fullDuplexPin = 1'b1;
    waitCycles(4);
    checkOutputs("R5 globals ignored");

    for (int i = 0; i < 40; i++) begin
      autoNegPin = 1'($urandom); speedPin = 1'($urandom);
      fullDuplexPin = 1'($urandom); fiberDuplexPin = 1'($urandom);
      mediaFiberPin = 4'($urandom);
      waitCycles(4);
      modelStraps();
      checkOutputs("R6 R7 manual random");
      doWrite(2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)),
              16'($urandom), 16'($urandom));
      doRead("R1 random locked", 2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)));
    end

    // back to write mode: writes work again, pins frozen
    manualModePin = 1'b0;
    waitCycles(6);
    manualModel = 0;
    doWrite(2'd3, 5'd0, 16'h2100, 16'hFFFF);
    doRead("R2 write restored", 2'd3, 5'd0);
    mediaFiberPin = ~mediaFiberPin; speedPin = ~speedPin;
    waitCycles(6);
    checkOutputs("R2 frozen after manual");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule